// File: doc/BRIEF.md
# Two-wire bus start/stop monitor

This block observes the clock and data lines of a shared two-wire serial bus and tracks bus ownership from the line conditions alone. Both lines are first brought into the local clock domain through a flop synchronizer. Two registered flags then record which bus condition was seen last. One flag records a start (data falling while the clock line is high). The other records a stop (data rising while the clock line is high). A controller that wants to become bus master reads the `bus_free` output and waits until it is high before it begins a transfer.

While the bus is in use, a one-cycle `stop_evt` pulse marks the moment another master releases it, so the controller can wait for an event and does not have to poll. Pulling `en` low, or applying reset, forgets all bus history. The bus then counts as idle and free. The block never drives either line.

Top module: `twowire_cond_monitor`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next outputs are `start_flag`=0, `stop_flag`=0 and `stop_evt`=0, with `bus_free`=1. A reset that is released while the clock line is low detects no condition.
- R2: A rising edge sampled with `en`=0 clears `start_flag` and `stop_flag` and forces `stop_evt` to 0. While `en` stays low, bus conditions set no flag and raise no pulse.
- R3: A start condition sets `start_flag`=1 and clears `stop_flag`. A start is SDA going 1 to 0 between two consecutive synchronized samples in which SCL is 1 in both. The flag changes on the third rising edge after the input change.
- R4: A stop condition sets `stop_flag`=1 and clears `start_flag`. A stop is SDA going 0 to 1 between two consecutive synchronized samples in which SCL is 1 in both. The flags are never both 1.
- R5: SDA changes while SCL is low leave both flags unchanged.
- R6: `bus_free` is 1 exactly when `stop_flag` is 1, or when both flags are 0. It follows the flags in the same cycle.
- R7: Each stop condition detected while enabled raises `stop_evt` for exactly one cycle, in the same cycle in which `stop_flag` shows the stop.
- R8: A start condition seen while `start_flag` is already 1 (a repeated start) keeps `start_flag`=1 and `bus_free`=0, and raises no `stop_evt`.
- R9: When `en` is low in the cycle in which a stop is detected, the disable wins: both flags end at 0, and `stop_evt` stays 0.
- R10: When SCL and SDA change in the same synchronized sample, no condition is detected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Monitor enable; low clears the history |
| scl_in | input | 1 | Raw bus clock line level |
| sda_in | input | 1 | Raw bus data line level |
| start_flag | output | 1 | Last condition seen was a start |
| stop_flag | output | 1 | Last condition seen was a stop |
| bus_free | output | 1 | Bus may be claimed by a new master |
| stop_evt | output | 1 | One-cycle pulse on each detected stop |

## Verification
Two functions can meet in one cycle: stop detection, which sets `stop_flag` and raises the pulse, and the disable clear. The bench provokes this by bringing SDA up while SCL is high. It then lowers `en` during the single cycle in which the synchronized edge is visible to the detector. The outcome is judged by requiring both flags at 0, `bus_free` at 1 and no pulse in that cycle or the next. Vectors with SCL and SDA moving together, and with SDA moving under a low SCL, check that no false condition appears next to real ones.

// File: rtl/twm_pkg.sv
// Package: shared types for the two-wire condition monitor.
// Assumes: consumers import it before use.
package twm_pkg;
    // Pair of single-cycle condition strobes from the detector.
    typedef struct packed {
        logic start;
        logic stop;
    } cond_t;

    // Bit order of the line bundle passed through the synchronizer.
    localparam int LINE_W   = 2;
    localparam int SCL_BIT  = 1;
    localparam int SDA_BIT  = 0;
endpackage

// File: rtl/twm_sync.sv
// Module: twm_sync
// Brings asynchronous line levels into the clk domain through a shift chain.
// Assumes: STAGES >= 2; the reset value models an idle (high) bus.
module twm_sync #(
    parameter int              WIDTH     = 2,
    parameter int              STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    // Shift the raw levels one stage per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/twm_cond_detect.sv
// Module: twm_cond_detect
// Finds start and stop conditions by comparing the synchronized lines
// with their previous sample.
// Assumes: inputs already synchronized; SCL must be high in both samples.
module twm_cond_detect
    import twm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  scl_s,
    input  logic  sda_s,
    output cond_t cond
);
    logic scl_prev;
    logic sda_prev;

    // Hold the previous sample of both lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    // Decode the data-line edge under a steady-high clock line.
    always_comb begin
        cond.start = scl_s & scl_prev &  sda_prev & ~sda_s;
        cond.stop  = scl_s & scl_prev & ~sda_prev &  sda_s;
    end

    // R10
    scl_rise_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_s) |-> (!cond.start && !cond.stop));
endmodule

// File: rtl/twm_flags.sv
// Module: twm_flags
// Holds the start-seen and stop-seen flags and produces the stop pulse.
// Assumes: cond strobes last one cycle; en is already in the clk domain.
module twm_flags
    import twm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en,
    input  cond_t cond,
    output logic  start_q,
    output logic  stop_q,
    output logic  stop_evt
);
    // Update the flags from the strobes; disable or reset wipes history.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            start_q  <= 1'b0;
            stop_q   <= 1'b0;
            stop_evt <= 1'b0;
        end else begin
            stop_evt <= cond.stop;
            if (cond.start) begin
                start_q <= 1'b1;
                stop_q  <= 1'b0;
            end else if (cond.stop) begin
                start_q <= 1'b0;
                stop_q  <= 1'b1;
            end
        end
    end

    // R2
    disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!start_q && !stop_q && !stop_evt));
    // R3
    start_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cond.start) |=> (start_q && !stop_q));
    // R4
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_q && stop_q));
    // R7
    evt_with_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |-> stop_q);
    // R7
    evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !stop_evt);
endmodule

// File: rtl/twowire_cond_monitor.sv
// Module: twowire_cond_monitor (top)
// Synchronizes SCL/SDA, detects start and stop conditions, keeps the
// last-condition flags and reports whether the bus may be claimed.
// Assumes: SYNC_STAGES >= 2; the bus idles high.
module twowire_cond_monitor
    import twm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic scl_in,
    input  logic sda_in,
    output logic start_flag,
    output logic stop_flag,
    output logic bus_free,
    output logic stop_evt
);
    logic [LINE_W-1:0] lines_raw;
    logic [LINE_W-1:0] lines_s;
    cond_t             cond;

    // Bundle the raw lines for the synchronizer.
    always_comb begin
        lines_raw          = '0;
        lines_raw[SCL_BIT] = scl_in;
        lines_raw[SDA_BIT] = sda_in;
    end

    twm_sync #(
        .WIDTH     (LINE_W),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL ({LINE_W{1'b1}})
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (lines_raw),
        .q     (lines_s)
    );

    twm_cond_detect det_i (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_s (lines_s[SCL_BIT]),
        .sda_s (lines_s[SDA_BIT]),
        .cond  (cond)
    );

    twm_flags flags_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .cond     (cond),
        .start_q  (start_flag),
        .stop_q   (stop_flag),
        .stop_evt (stop_evt)
    );

    // Free after a stop, or when no condition has been seen.
    assign bus_free = stop_flag | ~(start_flag | stop_flag);

    // R5
    low_clock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !lines_s[SCL_BIT]) |=> ($stable(start_flag) && $stable(stop_flag)));
    // R6
    busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_flag |-> !bus_free);
endmodule

// File: tb/twowire_cond_monitor_tb_top.sv
`timescale 1ns/1ps
module twowire_cond_monitor_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b1;
    logic scl_in = 1'b1;
    logic sda_in = 1'b1;
    logic start_flag, stop_flag, bus_free, stop_evt;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    twowire_cond_monitor dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .scl_in     (scl_in),
        .sda_in     (sda_in),
        .start_flag (start_flag),
        .stop_flag  (stop_flag),
        .bus_free   (bus_free),
        .stop_evt   (stop_evt)
    );

    // Vector fields: [5]=scl [4]=sda [3]=start [2]=stop [1]=free [0]=evt
    localparam int NVEC = 20;
    localparam logic [5:0] VEC [NVEC] = '{
        6'b11_0010, // idle                  R1 R6
        6'b10_1000, // start                 R3
        6'b00_1000,
        6'b01_1000, // data change, SCL low  R5
        6'b11_1000,
        6'b01_1000,
        6'b00_1000, // data change, SCL low  R5
        6'b10_1000,
        6'b11_0111, // stop + pulse          R4 R7
        6'b10_1000, // start                 R3
        6'b00_1000,
        6'b01_1000,
        6'b11_1000,
        6'b10_1000, // repeated start        R8
        6'b00_1000,
        6'b10_1000,
        6'b11_0111, // stop                  R4 R7
        6'b01_0110,
        6'b00_0110, // data change, SCL low  R5
        6'b11_0110  // both lines together   R10
    };

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b (start,stop,free,evt)", tag, act, exp);
        end
    endtask

    task automatic apply(input logic scl, input logic sda);
        @(negedge clk);
        scl_in = scl;
        sda_in = sda;
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [3:0] outs();
        return {start_flag, stop_flag, bus_free, stop_evt};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset state", outs(), 4'b0010);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][5], VEC[i][4]);
            chk($sformatf("R3/R4/R5/R6/R7/R8/R10 vector %0d", i), outs(), VEC[i][3:0]);
        end
        @(negedge clk);
        chk("R7 pulse gone next cycle", outs(), 4'b0110);

        // R2: disable clears, conditions ignored while disabled
        apply(1'b1, 1'b0);
        chk("R3 start before disable", outs(), 4'b1000);
        en = 1'b0;
        @(negedge clk);
        chk("R2 disable clears flags", outs(), 4'b0010);
        begin
            logic seen = 1'b0;
            sda_in = 1'b1;
            repeat (4) begin @(negedge clk); seen |= stop_evt | stop_flag | start_flag; end
            sda_in = 1'b0;
            repeat (4) begin @(negedge clk); seen |= stop_evt | stop_flag | start_flag; end
            chk("R2 no flag or pulse while disabled", {3'b000, seen}, 4'b0000);
        end
        en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2 re-enable keeps idle", outs(), 4'b0010);

        // R9: disable in the same cycle as stop detection
        @(negedge clk);
        sda_in = 1'b1;
        repeat (2) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk("R9 disable wins over stop", outs(), 4'b0010);
        @(negedge clk);
        chk("R9 no late pulse", outs(), 4'b0010);
        en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 idle after re-enable", outs(), 4'b0010);

        // R1: reset in mid-transfer, released with SCL low
        apply(1'b1, 1'b0);
        apply(1'b0, 1'b0);
        chk("R3 start before reset", outs(), 4'b1000);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset clears flags", outs(), 4'b0010);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 no condition after release", outs(), 4'b0010);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule